// File: doc/BRIEF.md
# Block-Stepped Line Distance Incrementer

This block serves one angle of a line-voting accelerator. For each block of a binary edge image that survives zero-run compression, it computes the signed fixed-point distance of the block's reference pixel from the origin along the configured angle's normal. It needs no multiplier. A row accumulator moves by one block-height increment at the start of every block-row. A column accumulator moves from one kept block to the next by a single addition. The value it adds comes from a small table indexed by the zero-run count that the previous kept block carried. Entry k of that table holds the distance change for a move of k+1 block widths.

Compressed symbols enter on a valid/ready stream, one per clock. Each symbol carries a row-start flag, the block's pixel bits and the number of all-zero blocks that follow it. Results leave on a registered valid/ready stream. Each result carries the integer part, the fractional part and the unchanged pixel bits. The output register holds its contents while the consumer stalls, and input ready falls in that same cycle, so no symbol is lost. Before an angle runs, a host loads the step table, the row increment and the initial row value through a plain write port, and then pulses the frame start. The first symbol of a frame must have its row-start flag set.

Top module: `hrho_incrementer`

## Requirements
- R1: After reset, out_valid and in_ready are low.
- R2: A frame_start pulse loads the row accumulator with the initial value held at configuration address 17, so the first row-start symbol of the frame yields exactly that value.
- R3: Each accepted symbol with in_row_start high yields the current row accumulator value, and the row accumulator then gains the row increment held at address 16.
- R4: An accepted symbol with in_row_start low yields the previous result plus step entry r, where r is the in_run field of the previous accepted symbol.
- R5: Configuration addresses 0 to 15 write step entries 0 to 15. Address 16 writes the row increment and address 17 writes the initial value. Writes to any other address change nothing.
- R6: Configuration writes made while a frame is active (from the cycle after frame_start until the cycle after frame_stop) are ignored. Writes made while idle take effect.
- R7: Results are two's complement with the low FRAC_W bits on out_frac and the upper INT_W bits on out_int, so that a value of -1.375 gives out_int = -2 and out_frac = 0xA00.
- R8: When out_ready is high, one symbol is accepted per clock, and each result appears on the output one cycle after its symbol is accepted, in order.
- R9: While out_valid is high and out_ready is low, the output holds its value and in_ready is low.
- R10: in_ready is low while no frame is active, and it goes low in the cycle after a frame_stop (unless frame_start is also high).
- R11: out_pix equals the in_pix of the symbol that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse that loads the row accumulator and starts a frame |
| frame_stop | input | 1 | Pulse that ends the frame |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W (5) | Configuration address: 0-15 step entries, 16 row increment, 17 initial value |
| cfg_data | input | INT_W+FRAC_W (23) | Signed fixed-point configuration value |
| in_valid | input | 1 | Symbol valid |
| in_ready | output | 1 | Symbol accepted when high together with in_valid |
| in_row_start | input | 1 | Symbol is the first block of a block-row |
| in_pix | input | PIX_W (8) | Pixel bits of the block |
| in_run | input | RUN_W (4) | Count of zero blocks skipped after this block |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready |
| out_int | output | INT_W (11) | Signed integer part of the distance |
| out_frac | output | FRAC_W (12) | Fractional part of the distance |
| out_pix | output | PIX_W (8) | Pixel bits passed through with the result |

## Verification
On every cycle, the assertions check the stream handshake: results hold under a stall, every accepted symbol produces a result in the next cycle, the pixel bits travel with their result, a stop closes the input, and a row-start symbol that directly follows frame_start yields the loaded initial value. Only the bench's scenarios can show the arithmetic. They cover step selection through the previous symbol's run count, the row increment across several block-rows, the negative fixed-point split, the write decode and the lockout of configuration writes during a frame, because each of these needs a reference model of the accumulated sums.

// File: rtl/hrho_pkg.sv
package hrho_pkg;

  typedef enum logic [1:0] {
    CFG_STEP    = 2'd0,
    CFG_ROW_INC = 2'd1,
    CFG_INIT    = 2'd2,
    CFG_NONE    = 2'd3
  } cfg_kind_e;

  function automatic int unsigned cfg_addr_width(int unsigned steps);
    return $clog2(steps + 2);
  endfunction

  function automatic cfg_kind_e cfg_decode(int unsigned addr, int unsigned steps);
    if (addr < steps)           return CFG_STEP;
    else if (addr == steps)     return CFG_ROW_INC;
    else if (addr == steps + 1) return CFG_INIT;
    else                        return CFG_NONE;
  endfunction

endpackage

// File: rtl/hrho_step_table.sv
module hrho_step_table #(
  parameter int VAL_W = 23,
  parameter int RUN_W = 4,
  localparam int NSTEP = 2 ** RUN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [RUN_W-1:0]        waddr,
  input  logic signed [VAL_W-1:0] wdata,
  input  logic [RUN_W-1:0]        raddr,
  output logic signed [VAL_W-1:0] rdata
);

  logic signed [VAL_W-1:0] entry_q [NSTEP];

  for (genvar k = 0; k < NSTEP; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) entry_q[k] <= '0;
      else if (we && (waddr == RUN_W'(k))) entry_q[k] <= wdata;
    end
  end

  assign rdata = entry_q[raddr];

endmodule

// File: rtl/hrho_config.sv
module hrho_config
  import hrho_pkg::*;
#(
  parameter int VAL_W  = 23,
  parameter int RUN_W  = 4,
  parameter int ADDR_W = 5,
  localparam int NSTEP = 2 ** RUN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_active,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic signed [VAL_W-1:0] cfg_data,
  input  logic [RUN_W-1:0]        step_raddr,
  output logic signed [VAL_W-1:0] step_rdata,
  output logic signed [VAL_W-1:0] row_inc,
  output logic signed [VAL_W-1:0] init_val
);

  cfg_kind_e kind;
  logic      wr_ok;

  always_comb begin
    kind  = cfg_decode(int'(cfg_addr), NSTEP);
    wr_ok = cfg_we && !frame_active;
  end

  hrho_step_table #(.VAL_W(VAL_W), .RUN_W(RUN_W)) u_steps (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_ok && (kind == CFG_STEP)),
    .waddr (cfg_addr[RUN_W-1:0]),
    .wdata (cfg_data),
    .raddr (step_raddr),
    .rdata (step_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_inc  <= '0;
      init_val <= '0;
    end else if (wr_ok) begin
      if (kind == CFG_ROW_INC) row_inc  <= cfg_data;
      if (kind == CFG_INIT)    init_val <= cfg_data;
    end
  end

endmodule

// File: rtl/hrho_row_acc.sv
module hrho_row_acc #(
  parameter int VAL_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [VAL_W-1:0] init_val,
  input  logic                    advance,
  input  logic signed [VAL_W-1:0] row_inc,
  output logic signed [VAL_W-1:0] row_val
);

  always_ff @(posedge clk) begin
    if (!rst_n)       row_val <= '0;
    else if (load)    row_val <= init_val;
    else if (advance) row_val <= row_val + row_inc;
  end

endmodule

// File: rtl/hrho_col_stage.sv
module hrho_col_stage #(
  parameter int VAL_W = 23,
  parameter int RUN_W = 4,
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    sym_row_start,
  input  logic [PIX_W-1:0]        sym_pix,
  input  logic [RUN_W-1:0]        sym_run,
  input  logic signed [VAL_W-1:0] row_val,
  output logic [RUN_W-1:0]        step_raddr,
  input  logic signed [VAL_W-1:0] step_rdata,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic signed [VAL_W-1:0] out_val,
  output logic [PIX_W-1:0]        out_pix
);

  logic signed [VAL_W-1:0] col_q;
  logic signed [VAL_W-1:0] col_nxt;
  logic [RUN_W-1:0]        prev_run_q;

  assign step_raddr = prev_run_q;

  always_comb begin
    if (sym_row_start) col_nxt = row_val;
    else               col_nxt = col_q + step_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q      <= '0;
      prev_run_q <= '0;
    end else if (accept) begin
      col_q      <= col_nxt;
      prev_run_q <= sym_run;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_val   <= '0;
      out_pix   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_val   <= col_nxt;
      out_pix   <= sym_pix;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/hrho_incrementer.sv
module hrho_incrementer
  import hrho_pkg::*;
#(
  parameter int FRAC_W = 12,
  parameter int INT_W  = 11,
  parameter int RUN_W  = 4,
  parameter int PIX_W  = 8,
  localparam int VAL_W  = INT_W + FRAC_W,
  localparam int ADDR_W = cfg_addr_width(2 ** RUN_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     frame_stop,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic signed [VAL_W-1:0]  cfg_data,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_row_start,
  input  logic [PIX_W-1:0]         in_pix,
  input  logic [RUN_W-1:0]         in_run,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [INT_W-1:0]  out_int,
  output logic [FRAC_W-1:0]        out_frac,
  output logic [PIX_W-1:0]         out_pix
);

  logic                    active_q;
  logic                    accept;
  logic [RUN_W-1:0]        step_raddr;
  logic signed [VAL_W-1:0] step_rdata;
  logic signed [VAL_W-1:0] row_inc;
  logic signed [VAL_W-1:0] init_val;
  logic signed [VAL_W-1:0] row_val;
  logic signed [VAL_W-1:0] out_val;

  always_ff @(posedge clk) begin
    if (!rst_n)           active_q <= 1'b0;
    else if (frame_start) active_q <= 1'b1;
    else if (frame_stop)  active_q <= 1'b0;
  end

  assign in_ready = active_q && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  hrho_config #(.VAL_W(VAL_W), .RUN_W(RUN_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (active_q),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_data     (cfg_data),
    .step_raddr   (step_raddr),
    .step_rdata   (step_rdata),
    .row_inc      (row_inc),
    .init_val     (init_val)
  );

  hrho_row_acc #(.VAL_W(VAL_W)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .init_val (init_val),
    .advance  (accept && in_row_start),
    .row_inc  (row_inc),
    .row_val  (row_val)
  );

  hrho_col_stage #(.VAL_W(VAL_W), .RUN_W(RUN_W), .PIX_W(PIX_W)) u_col (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .sym_row_start (in_row_start),
    .sym_pix       (in_pix),
    .sym_run       (in_run),
    .row_val       (row_val),
    .step_raddr    (step_raddr),
    .step_rdata    (step_rdata),
    .out_ready     (out_ready),
    .out_valid     (out_valid),
    .out_val       (out_val),
    .out_pix       (out_pix)
  );

  assign out_int  = out_val[VAL_W-1:FRAC_W];
  assign out_frac = out_val[FRAC_W-1:0];

endmodule

// File: rtl/hrho_incrementer_chk.sv
module hrho_incrementer_chk #(
  parameter int FRAC_W = 12,
  parameter int INT_W  = 11,
  parameter int PIX_W  = 8,
  localparam int VAL_W = INT_W + FRAC_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frame_start,
  input logic                    frame_stop,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_row_start,
  input logic [PIX_W-1:0]        in_pix,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [INT_W-1:0] out_int,
  input logic [FRAC_W-1:0]       out_frac,
  input logic [PIX_W-1:0]        out_pix,
  input logic signed [VAL_W-1:0] init_val
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_int) && $stable(out_frac) && $stable(out_pix))); // R9

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8

  AST_PIX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_pix == $past(in_pix))); // R11

  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stop && !frame_start) |=> !in_ready); // R10

  AST_FIRST_ROW_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_row_start && $past(frame_start))
      |=> ({out_int, out_frac} == $past(init_val))); // R2

endmodule

bind hrho_incrementer hrho_incrementer_chk #(
  .FRAC_W(FRAC_W), .INT_W(INT_W), .PIX_W(PIX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .frame_stop   (frame_stop),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_row_start (in_row_start),
  .in_pix       (in_pix),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_int      (out_int),
  .out_frac     (out_frac),
  .out_pix      (out_pix),
  .init_val     (init_val)
);

// File: tb/hrho_incrementer_tb_top.sv
module hrho_incrementer_tb_top;

  localparam int FRAC_W = 12;
  localparam int INT_W  = 11;
  localparam int RUN_W  = 4;
  localparam int PIX_W  = 8;
  localparam int VAL_W  = INT_W + FRAC_W;
  localparam int ADDR_W = 5;
  localparam int NSTEP  = 2 ** RUN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic frame_stop = 1'b0;
  logic cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic signed [VAL_W-1:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_row_start = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic [RUN_W-1:0] in_run = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [INT_W-1:0] out_int;
  logic [FRAC_W-1:0] out_frac;
  logic [PIX_W-1:0] out_pix;

  always #4 clk = ~clk;

  hrho_incrementer #(.FRAC_W(FRAC_W), .INT_W(INT_W), .RUN_W(RUN_W), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_stop(frame_stop),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_row_start(in_row_start),
    .in_pix(in_pix), .in_run(in_run), .out_valid(out_valid), .out_ready(out_ready),
    .out_int(out_int), .out_frac(out_frac), .out_pix(out_pix)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic signed [VAL_W-1:0] val;
    logic [PIX_W-1:0]        pix;
    string                   tag;
  } exp_t;
  exp_t exp_q[$];

  logic signed [VAL_W-1:0] m_step [NSTEP];
  logic signed [VAL_W-1:0] m_row_inc = '0;
  logic signed [VAL_W-1:0] m_init = '0;
  logic signed [VAL_W-1:0] m_row = '0;
  logic signed [VAL_W-1:0] m_col = '0;
  logic [RUN_W-1:0] m_prev = '0;
  bit m_active = 1'b0;

  bit bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  int acc_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (bp_en) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0];
    end else begin
      out_ready = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on every transfer, stall-hold check (R9)
  logic stalled_prev = 1'b0;
  logic signed [INT_W-1:0] s_int;
  logic [FRAC_W-1:0] s_frac;
  logic [PIX_W-1:0] s_pix;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled_prev) begin
        check(out_valid && out_int == s_int && out_frac == s_frac && out_pix == s_pix,
              "R9", "held output", longint'({out_valid, out_int, out_frac}),
              longint'({1'b1, s_int, s_frac}));
      end
      stalled_prev = out_valid && !out_ready;
      s_int = out_int; s_frac = out_frac; s_pix = out_pix;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected output", longint'(out_pix), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_int == e.val[VAL_W-1:FRAC_W] && out_frac == e.val[FRAC_W-1:0],
                e.tag, "distance", longint'({out_int, out_frac}), longint'(e.val));
          check(out_pix == e.pix, "R11", "pixels", longint'(out_pix), longint'(e.pix));
        end
      end
    end
  end

  task automatic cfg_write(input int addr, input logic signed [VAL_W-1:0] data);
    cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_data = data;
    @(posedge clk);
    if (!m_active) begin
      if (addr < NSTEP) m_step[addr] = data;
      else if (addr == NSTEP) m_row_inc = data;
      else if (addr == NSTEP + 1) m_init = data;
    end
    #1 cfg_we = 1'b0;
  endtask

  task automatic start_frame();
    frame_start = 1'b1;
    @(posedge clk);
    m_active = 1'b1; m_row = m_init;
    #1 frame_start = 1'b0;
  endtask

  task automatic stop_frame();
    frame_stop = 1'b1;
    @(posedge clk);
    m_active = 1'b0;
    #1 frame_stop = 1'b0;
  endtask

  task automatic send(input bit rs, input logic [PIX_W-1:0] pix,
                      input logic [RUN_W-1:0] run, input string tag);
    exp_t e;
    in_valid = 1'b1; in_row_start = rs; in_pix = pix; in_run = run;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    if (rs) begin
      e.val = m_row;
      m_row = m_row + m_row_inc;
    end else begin
      e.val = m_col + m_step[m_prev];
    end
    m_col = e.val; m_prev = run; e.pix = pix; e.tag = tag;
    exp_q.push_back(e);
    #1;
    acc_cyc = cyc;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int t0;
    for (int k = 0; k < NSTEP; k++) m_step[k] = '0;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b0, "R10", "in_ready with no frame", longint'(in_ready), 0);
    @(posedge clk); #1;

    // R5 configuration: step k moves k+1 block widths
    for (int k = 0; k < NSTEP; k++) cfg_write(k, VAL_W'((k + 1) * 32'h1A3C));
    cfg_write(NSTEP, -VAL_W'(32'h3400));
    cfg_write(NSTEP + 1, VAL_W'(32'h5200));
    cfg_write(20, VAL_W'(32'h7FFFF)); // R5 out-of-range, aliases step 4 if decode is partial
    cfg_write(18, VAL_W'(32'h12345)); // R5 out-of-range

    start_frame();
    @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready in frame", longint'(in_ready), 1);
    @(posedge clk); #1;

    // row 0
    send(1'b1, 8'h81, 4'd4, "R2");
    send(1'b0, 8'h3C, 4'd15, "R5");   // uses step 4
    send(1'b0, 8'h01, 4'd0, "R4");    // uses step 15
    send(1'b0, 8'hF0, 4'd2, "R4");    // uses step 0
    // row 1
    send(1'b1, 8'h10, 4'd7, "R3");
    send(1'b0, 8'h22, 4'd3, "R4");    // uses step 7
    // R6: writes during frame must be ignored
    cfg_write(NSTEP + 1, VAL_W'(32'h1));
    cfg_write(3, VAL_W'(32'h77777));
    cfg_write(NSTEP, VAL_W'(32'h2));
    // row 2: value -1.375
    send(1'b1, 8'h55, 4'd3, "R7");
    send(1'b0, 8'hAA, 4'd1, "R6");    // uses step 3
    // row 3: back-to-back burst
    send(1'b1, 8'h01, 4'd1, "R3");
    t0 = acc_cyc;
    for (int i = 0; i < 6; i++) send(1'b0, PIX_W'(i + 2), 4'd1, "R8");
    check(acc_cyc - t0 == 6, "R8", "cycles for six symbols", acc_cyc - t0, 6);
    // rows 4-5 under back-pressure
    bp_en = 1'b1;
    send(1'b1, 8'h0F, 4'd5, "R3");
    for (int i = 0; i < 5; i++) send(1'b0, PIX_W'(8'h40 + i), RUN_W'(i * 3), "R9");
    send(1'b1, 8'hE0, 4'd9, "R3");
    for (int i = 0; i < 4; i++) send(1'b0, PIX_W'(8'h80 + i), RUN_W'(15 - i), "R9");
    drain();
    bp_en = 1'b0;
    @(posedge clk); #1;

    stop_frame();
    @(negedge clk);
    check(in_ready == 1'b0, "R10", "in_ready after stop", longint'(in_ready), 0);
    @(posedge clk); #1;

    // R6: writes while idle take effect
    cfg_write(NSTEP + 1, VAL_W'(32'h2000));
    cfg_write(0, -VAL_W'(32'h0800));
    start_frame();
    send(1'b1, 8'h99, 4'd0, "R6");
    send(1'b0, 8'h66, 4'd0, "R6");
    send(1'b1, 8'h11, 4'd0, "R3");
    drain();
    stop_frame();
    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule